// File: doc/BRIEF.md
# Counter and Trigger-Control CSR Unit with Side-Effect Arbitration

This block holds two control-and-status registers for a single-issue core. The first is a 64-bit count of retired instructions, which the hardware bumps by one whenever an instruction retires. The second is a 32-bit trigger-control word. It carries a hit flag that the hardware raises when an address-match trigger fires. Software reaches both registers through a CSR access port. The port offers replace, set-bits and clear-bits operations, each with a data/mask operand.

Each cycle stands for one instruction. In that cycle the block settles the conflict between an explicit software write and a hardware side-effect update to the same register. A read always returns the value from before the instruction. An explicit write replaces the side effect of that same instruction, and this holds even for bits the mask leaves untouched. A trigger that halts the instruction (timing before, action 0 or 1) cancels the instruction's access and its retirement. A trigger with timing after is applied on top of the instruction's write.

Top module: `csr_sidefx_unit`

## Requirements
- R1: A synchronous active-high reset clears the counter and the trigger-control word to zero. Retire and trigger inputs present during reset have no effect.
- R2: `acc_rdata` shows, in the same cycle, the value held before the current instruction. Address 0x100 gives counter bits 31:0, 0x101 gives counter bits 63:32, 0x110 gives the trigger-control word, and any other address gives zero.
- R3: `acc_op` is encoded as 0 = replace, 1 = set the bits given in `acc_wdata`, 2 = clear the bits given in `acc_wdata`, 3 = no write. The result appears at the outputs one clock later.
- R4: A retiring instruction that does not write the counter adds one to the full 64-bit count. The carry runs from the low half into the high half, and the count wraps from all ones to zero.
- R5: A write to either counter half takes effect and the increment for that instruction is dropped. The other half keeps its value.
- R6: A set or clear operation with `acc_src_x0` high is not a write. The counter increment and the hit update still take place.
- R7: When a trigger fires with timing before and action 2 to 7 on an instruction that writes the trigger-control word, the hit flag (bit 20) takes the written result, even if the mask excludes bit 20. Without such a write, the hit flag is set.
- R8: When a trigger fires with timing before and action 0 or 1, the instruction's CSR write and its retirement increment are discarded, and the hit flag is set.
- R9: When a trigger fires with timing after, the instruction's write is applied first and the hit flag is then set on top of the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | A CSR access instruction is present this cycle |
| acc_addr | input | 12 | CSR address |
| acc_op | input | 2 | Access operation: replace, set, clear, none |
| acc_wdata | input | 32 | Write data or bit mask |
| acc_src_x0 | input | 1 | Operand comes from the zero register |
| acc_rdata | output | 32 | Pre-instruction value of the addressed register |
| retire | input | 1 | The instruction of this cycle retires |
| trig_fire | input | 1 | The address-match trigger fires this cycle |
| trig_action | input | 3 | Trigger action code |
| trig_after | input | 1 | Trigger timing: 1 = after, 0 = before |
| cnt_out | output | 64 | Current retired-instruction count |
| tctl_out | output | 32 | Current trigger-control word |

## Verification
Read data is combinational, so the bench samples it one time unit after it drives an instruction at the falling edge, before any clock edge passes. The counter and the trigger-control word are each one register deep. Their new values are checked at the falling edge that follows the next rising edge. Each expected read value is the expected state carried over from the previous step of the vector walk.

// File: rtl/csr_sfx_pkg.sv
`timescale 1ns/1ps
package csr_sfx_pkg;

  typedef enum logic [1:0] {
    OP_RW   = 2'd0,
    OP_RS   = 2'd1,
    OP_RC   = 2'd2,
    OP_NONE = 2'd3
  } csr_op_e;

  // Result of a CSR access applied to an old register value.
  function automatic logic [31:0] csr_merge(input csr_op_e op,
                                            input logic [31:0] old_val,
                                            input logic [31:0] operand);
    case (op)
      OP_RW:   csr_merge = operand;
      OP_RS:   csr_merge = old_val | operand;
      OP_RC:   csr_merge = old_val & ~operand;
      default: csr_merge = old_val;
    endcase
  endfunction

endpackage

// File: rtl/csr_sfx_decode.sv
`timescale 1ns/1ps
module csr_sfx_decode
  import csr_sfx_pkg::*;
#(
  parameter int          ADDR_W       = 12,
  parameter int          NUM_HALVES   = 2,
  parameter int          ACT_W        = 3,
  parameter int          HALT_ACTIONS = 2,
  parameter logic [11:0] ADDR_CNT     = 12'h100,
  parameter logic [11:0] ADDR_TCTL    = 12'h110
) (
  input  logic                  valid,
  input  logic [ADDR_W-1:0]     addr,
  input  csr_op_e               op,
  input  logic                  src_x0,
  input  logic                  fire,
  input  logic [ACT_W-1:0]      action,
  input  logic                  after,
  output logic                  squash,
  output logic [NUM_HALVES-1:0] wr_half,
  output logic                  wr_tctl
);
  localparam logic [ACT_W-1:0] HALT_LIM = ACT_W'(HALT_ACTIONS);

  logic is_write;

  // A halting trigger taken before the instruction cancels it entirely.
  assign squash = fire && !after && (action < HALT_LIM);

  // Set/clear sourced from the zero register is a pure read.
  assign is_write = valid && !squash &&
                    ((op == OP_RW) ||
                     (((op == OP_RS) || (op == OP_RC)) && !src_x0));

  for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half_dec
    assign wr_half[g] = is_write && (addr == ADDR_W'(ADDR_CNT + 12'(g)));
  end

  assign wr_tctl = is_write && (addr == ADDR_W'(ADDR_TCTL));

endmodule

// File: rtl/csr_sfx_counter.sv
`timescale 1ns/1ps
module csr_sfx_counter
  import csr_sfx_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int CNT_W = 64,
  localparam int NUM_HALVES = CNT_W / XLEN
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  inc,
  input  logic [NUM_HALVES-1:0] wr_half,
  input  csr_op_e               op,
  input  logic [XLEN-1:0]       wdata,
  output logic [CNT_W-1:0]      cnt_q
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (|wr_half) begin
      // Explicit write replaces this instruction's increment.
      for (int g = 0; g < NUM_HALVES; g++) begin
        if (wr_half[g]) begin
          cnt_d[g*XLEN +: XLEN] = csr_merge(op, cnt_q[g*XLEN +: XLEN], wdata);
        end
      end
    end else if (inc) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  AST_CNT_INC: assert property (@(posedge clk) disable iff (rst)
    (inc && !(|wr_half)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R4

  AST_CNT_LO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_half[0] && op == OP_RW) |=>
      (cnt_q[XLEN-1:0] == $past(wdata)) &&
      (cnt_q[CNT_W-1:XLEN] == $past(cnt_q[CNT_W-1:XLEN]))); // R5

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!inc && !(|wr_half)) |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/csr_sfx_trigctl.sv
`timescale 1ns/1ps
module csr_sfx_trigctl
  import csr_sfx_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int HIT_BIT = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire,
  input  logic            after,
  input  logic            wr,
  input  csr_op_e         op,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] tctl_q
);
  logic [XLEN-1:0] tctl_d;

  always_comb begin
    tctl_d = wr ? csr_merge(op, tctl_q, wdata) : tctl_q;
    // Before-timing hit loses to an explicit write; after-timing is ordered last.
    if (fire && (after || !wr)) tctl_d[HIT_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) tctl_q <= '0;
    else     tctl_q <= tctl_d;
  end

  AST_HIT_AFTER: assert property (@(posedge clk) disable iff (rst)
    (fire && after) |=> tctl_q[HIT_BIT]); // R9

  AST_HIT_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (fire && !after && wr && op == OP_RW) |=>
      (tctl_q[HIT_BIT] == $past(wdata[HIT_BIT]))); // R7

  AST_HIT_KEPT_ON_RS: assert property (@(posedge clk) disable iff (rst)
    (fire && !after && wr && op == OP_RS) |=>
      (tctl_q[HIT_BIT] == ($past(tctl_q[HIT_BIT]) | $past(wdata[HIT_BIT])))); // R7

endmodule

// File: rtl/csr_sidefx_unit.sv
`timescale 1ns/1ps
module csr_sidefx_unit
  import csr_sfx_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          CNT_W     = 64,
  parameter int          ADDR_W    = 12,
  parameter int          ACT_W     = 3,
  parameter int          HIT_BIT   = 20,
  parameter logic [11:0] ADDR_CNT  = 12'h100,
  parameter logic [11:0] ADDR_TCTL = 12'h110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_op,
  input  logic [XLEN-1:0]   acc_wdata,
  input  logic              acc_src_x0,
  output logic [XLEN-1:0]   acc_rdata,
  input  logic              retire,
  input  logic              trig_fire,
  input  logic [ACT_W-1:0]  trig_action,
  input  logic              trig_after,
  output logic [CNT_W-1:0]  cnt_out,
  output logic [XLEN-1:0]   tctl_out
);
  localparam int              NUM_HALVES = CNT_W / XLEN;
  localparam logic [XLEN-1:0] HIT_MASK   = XLEN'(1) << HIT_BIT;

  csr_op_e               op;
  logic                  squash;
  logic [NUM_HALVES-1:0] wr_half;
  logic                  wr_tctl;

  assign op = csr_op_e'(acc_op);

  csr_sfx_decode #(
    .ADDR_W(ADDR_W), .NUM_HALVES(NUM_HALVES), .ACT_W(ACT_W),
    .HALT_ACTIONS(2), .ADDR_CNT(ADDR_CNT), .ADDR_TCTL(ADDR_TCTL)
  ) u_dec (
    .valid(acc_valid), .addr(acc_addr), .op(op), .src_x0(acc_src_x0),
    .fire(trig_fire), .action(trig_action), .after(trig_after),
    .squash(squash), .wr_half(wr_half), .wr_tctl(wr_tctl)
  );

  csr_sfx_counter #(.XLEN(XLEN), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(retire && !squash), .wr_half(wr_half),
    .op(op), .wdata(acc_wdata), .cnt_q(cnt_out)
  );

  csr_sfx_trigctl #(.XLEN(XLEN), .HIT_BIT(HIT_BIT)) u_tctl (
    .clk(clk), .rst(rst), .fire(trig_fire), .after(trig_after),
    .wr(wr_tctl), .op(op), .wdata(acc_wdata), .tctl_q(tctl_out)
  );

  // Reads see the state from before this instruction.
  always_comb begin
    acc_rdata = '0;
    for (int g = 0; g < NUM_HALVES; g++) begin
      if (acc_addr == ADDR_W'(ADDR_CNT + 12'(g))) acc_rdata = cnt_out[g*XLEN +: XLEN];
    end
    if (acc_addr == ADDR_W'(ADDR_TCTL)) acc_rdata = tctl_out;
  end

  AST_HALT_CANCELS: assert property (@(posedge clk) disable iff (rst)
    (trig_fire && !trig_after && trig_action < ACT_W'(2)) |=>
      (tctl_out == ($past(tctl_out) | HIT_MASK)) && (cnt_out == $past(cnt_out))); // R8

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (cnt_out == '0) && (tctl_out == '0)); // R1

endmodule

// File: tb/csr_sidefx_unit_test.sv
`timescale 1ns/1ps
module csr_sidefx_unit_test;

  typedef struct packed {
    logic        v;
    logic [11:0] addr;
    logic [1:0]  op;
    logic [31:0] data;
    logic        x0;
    logic        ret;
    logic        fire;
    logic [2:0]  act;
    logic        aft;
    logic [63:0] ecnt;
    logic [31:0] etc;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h000, 2'd0, 32'h0,        1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 64'h1,  32'h0},        // R4
    '{1'b0, 12'h000, 2'd0, 32'h0,        1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 64'h2,  32'h0},        // R4
    '{1'b1, 12'h100, 2'd0, 32'h10,       1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 64'h10, 32'h0},        // R5
    '{1'b0, 12'h000, 2'd0, 32'h0,        1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 64'h11, 32'h0},        // R5
    '{1'b1, 12'h110, 2'd1, 32'hF0,       1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 64'h12, 32'hF0},       // R3
    '{1'b1, 12'h110, 2'd2, 32'h30,       1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 64'h13, 32'hC0},       // R3
    '{1'b0, 12'h000, 2'd0, 32'h0,        1'b0, 1'b1, 1'b1, 3'd2, 1'b0, 64'h14, 32'h001000C0}, // R7
    '{1'b1, 12'h110, 2'd2, 32'h00100000, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 64'h15, 32'hC0},       // R7
    '{1'b1, 12'h110, 2'd1, 32'h1,        1'b0, 1'b1, 1'b1, 3'd3, 1'b0, 64'h16, 32'hC1},       // R7
    '{1'b1, 12'h110, 2'd1, 32'h2,        1'b1, 1'b1, 1'b1, 3'd4, 1'b0, 64'h17, 32'h001000C1}, // R6
    '{1'b1, 12'h110, 2'd0, 32'h0,        1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 64'h18, 32'h0},        // R3
    '{1'b1, 12'h110, 2'd0, 32'h5,        1'b0, 1'b1, 1'b1, 3'd1, 1'b0, 64'h18, 32'h00100000}, // R8
    '{1'b1, 12'h110, 2'd0, 32'h7,        1'b0, 1'b1, 1'b1, 3'd2, 1'b1, 64'h19, 32'h00100007}, // R9
    '{1'b1, 12'h101, 2'd0, 32'hFFFFFFFF, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 64'hFFFFFFFF_00000019, 32'h00100007}, // R5
    '{1'b1, 12'h100, 2'd0, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 64'hFFFFFFFF_FFFFFFFF, 32'h00100007}, // R5
    '{1'b0, 12'h000, 2'd0, 32'h0,        1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 64'h0,  32'h00100007}, // R4
    '{1'b1, 12'h100, 2'd2, 32'h0,        1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 64'h1,  32'h00100007}, // R6
    '{1'b1, 12'h100, 2'd3, 32'h5,        1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 64'h2,  32'h00100007}  // R3
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [11:0] acc_addr = '0;
  logic [1:0]  acc_op = '0;
  logic [31:0] acc_wdata = '0;
  logic        acc_src_x0 = 1'b0;
  logic [31:0] acc_rdata;
  logic        retire = 1'b0;
  logic        trig_fire = 1'b0;
  logic [2:0]  trig_action = '0;
  logic        trig_after = 1'b0;
  logic [63:0] cnt_out;
  logic [31:0] tctl_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  csr_sidefx_unit uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_op(acc_op), .acc_wdata(acc_wdata), .acc_src_x0(acc_src_x0),
    .acc_rdata(acc_rdata), .retire(retire), .trig_fire(trig_fire),
    .trig_action(trig_action), .trig_after(trig_after),
    .cnt_out(cnt_out), .tctl_out(tctl_out)
  );

  function automatic string req_of(int i);
    case (i)
      0, 1, 15:       req_of = "R4";
      2, 3, 13, 14:   req_of = "R5";
      4, 5, 10, 17:   req_of = "R3";
      6, 7, 8:        req_of = "R7";
      9, 16:          req_of = "R6";
      11:             req_of = "R8";
      default:        req_of = "R9";
    endcase
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    acc_valid = 1'b0; acc_addr = '0; acc_op = '0; acc_wdata = '0;
    acc_src_x0 = 1'b0; retire = 1'b0; trig_fire = 1'b0;
    trig_action = '0; trig_after = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] pc;
    logic [31:0] pt;
    logic [31:0] rexp;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    check("R1", "cnt after reset", cnt_out, 64'h0);
    check("R1", "tctl after reset", {32'h0, tctl_out}, 64'h0);

    pc = 64'h0;
    pt = 32'h0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      acc_valid = VECS[i].v;   acc_addr = VECS[i].addr; acc_op = VECS[i].op;
      acc_wdata = VECS[i].data; acc_src_x0 = VECS[i].x0; retire = VECS[i].ret;
      trig_fire = VECS[i].fire; trig_action = VECS[i].act; trig_after = VECS[i].aft;
      #1;
      if (VECS[i].v) begin
        // R2: read returns the pre-instruction value
        case (VECS[i].addr)
          12'h100: rexp = pc[31:0];
          12'h101: rexp = pc[63:32];
          12'h110: rexp = pt;
          default: rexp = 32'h0;
        endcase
        check("R2", $sformatf("rdata vec %0d", i), {32'h0, acc_rdata}, {32'h0, rexp});
      end
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
      check(req_of(i), $sformatf("cnt vec %0d", i), cnt_out, VECS[i].ecnt);
      check(req_of(i), $sformatf("tctl vec %0d", i), {32'h0, tctl_out}, {32'h0, VECS[i].etc});
      pc = VECS[i].ecnt;
      pt = VECS[i].etc;
    end

    // R2: unmapped address reads zero
    acc_valid = 1'b1; acc_addr = 12'h1FF; acc_op = 2'd3;
    #1;
    check("R2", "unmapped read", {32'h0, acc_rdata}, 64'h0);
    acc_addr = 12'h101;
    #1;
    check("R2", "counter high read", {32'h0, acc_rdata}, 64'h0);
    idle_inputs();

    // R8: halting trigger with hit clear cancels write and increment, sets hit
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = 12'h110; acc_op = 2'd0; acc_wdata = 32'h0;
    retire = 1'b1;
    @(posedge clk);
    @(negedge clk);
    acc_addr = 12'h100; acc_op = 2'd0; acc_wdata = 32'h55; retire = 1'b1;
    trig_fire = 1'b1; trig_action = 3'd0; trig_after = 1'b0;
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    check("R8", "cnt after halting trigger", cnt_out, 64'h3);
    check("R8", "tctl after halting trigger", {32'h0, tctl_out}, 64'h00100000);

    // R1: reset wins over retire and trigger
    rst = 1'b1; retire = 1'b1; trig_fire = 1'b1; trig_action = 3'd2;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    idle_inputs();
    check("R1", "cnt after mid-run reset", cnt_out, 64'h0);
    check("R1", "tctl after mid-run reset", {32'h0, tctl_out}, 64'h0);

    finish_run();
  end

endmodule